// File: doc/BRIEF.md
# Event-Triggered Counter Capture Unit

This block records the value of a free-running time-base counter when a filtered compare event goes from low to high. Each capture closes a window: later event edges are dropped until the counter reaches a chosen boundary. That boundary is either the period match or the zero point. Counter generation and event filtering happen outside the block. It receives the counter value, a period strobe, a zero strobe and the already filtered event.

The captured value sits in an active register. An optional shadow copy takes the active value at the same boundary that reopens the capture window. Software reads both through one address. A mode bit picks which one the read returns: the shadow, which is the default, or the active register directly. The read port is read-only, and its data arrives one cycle after the read strobe.

Capture control is a three-state machine. The states are IDLE (capture disabled), ARMED (the next rising edge is taken) and LOCKED (edges are dropped). The transitions are:
- EN_ON: IDLE to ARMED, when the enable is set and no edge arrives.
- TAKE: IDLE or ARMED to LOCKED, when an enabled rising edge arrives.
- RETAKE: LOCKED to LOCKED, when an edge arrives in the same cycle as the boundary.
- REOPEN: LOCKED to ARMED, when the boundary arrives with no edge.
- EN_OFF: any state to IDLE, when the enable is clear.

Top module: `capture_window_unit`

## Requirements
- R1: After reset the active and shadow registers are 0, and a read of the capture address returns 0.
- R2: While `cap_en` is 0, no event edge changes the active register.
- R3: While `cap_en` is 1 and the window is open, a rising edge of `evt_in` stores `tb_count` of that cycle into the active register. The edge is `evt_in` high in a cycle after a cycle in which it was low. A level held high produces only one capture.
- R4: After a capture, further edges are ignored until the selected boundary. The boundary is `prd_hit` when `bnd_sel` is 1 and `zero_hit` when `bnd_sel` is 0. The strobe that is not selected does not reopen the window.
- R5: When an edge coincides with the selected boundary strobe, the capture is taken and the window closes again.
- R6: While `cap_en` is 0 the lockout is cleared, so the first rising edge seen with `cap_en` at 1 is always captured.
- R7: With `shdw_bypass` at 0, the active value is copied into the shadow at each selected boundary. The copy takes the value held before any capture in that same cycle. Reads return the shadow.
- R8: With `shdw_bypass` at 1, reads return the active register and the shadow is not refreshed.
- R9: A read strobe gives `rd_valid` high and `rd_data` on the next cycle. The data is the selected register when `addr` equals `CAP_ADDR` and 0 otherwise. With no strobe, `rd_valid` is 0.
- R10: Write strobes and write data change neither register nor the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_count | input | 16 | Time-base counter value |
| prd_hit | input | 1 | Counter equals period strobe |
| zero_hit | input | 1 | Counter equals zero strobe |
| evt_in | input | 1 | Filtered compare event |
| cap_en | input | 1 | Capture enable |
| shdw_bypass | input | 1 | 1: reads see the active register; 0: reads see the shadow |
| bnd_sel | input | 1 | 1: period boundary; 0: zero boundary |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe (ignored) |
| addr | input | 4 | Register address |
| wr_data | input | 16 | Write data (ignored) |
| rd_data | output | 16 | Read data, one cycle after `rd_stb` |
| rd_valid | output | 1 | Read data valid |

## Verification
The assertions assume that `evt_in` is synchronous to `clk` and arrives already filtered. They also assume the strobes are single-cycle levels sampled at each edge. They do not assume that `prd_hit` and `zero_hit` are exclusive, or that they agree with `tb_count`. The bench drives a counter that wraps at a fixed period, and it raises each strobe exactly when the counter reaches the matching value. Random event levels, enable and mode bits are layered on top of that counter. Directed steps place edges on boundaries, on the boundary that is not selected, and across enable changes.

// File: rtl/cwu_pkg.sv
package cwu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } cwu_state_e;
endpackage

// File: rtl/cwu_edge_det.sv
module cwu_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/cwu_arm_fsm.sv
module cwu_arm_fsm
    import cwu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic rise,
    input  logic bnd,
    output logic take,
    output logic locked
);
    cwu_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cap_en && rise) begin
                    take    = 1'b1;          // TAKE
                    state_d = ST_LOCKED;
                end else if (cap_en) begin
                    state_d = ST_ARMED;      // EN_ON
                end
            end
            ST_ARMED: begin
                if (cap_en && rise) begin
                    take    = 1'b1;          // TAKE
                    state_d = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (cap_en && rise && bnd) begin
                    take    = 1'b1;          // RETAKE
                    state_d = ST_LOCKED;
                end else if (bnd) begin
                    state_d = ST_ARMED;      // REOPEN
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!cap_en) state_d = ST_IDLE;      // EN_OFF
    end

    assign locked = (state_q == ST_LOCKED);
endmodule

// File: rtl/cwu_cap_regs.sv
module cwu_cap_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          bnd,
    input  logic          shdw_bypass,
    input  logic [DW-1:0] cnt,
    output logic [DW-1:0] act_val,
    output logic [DW-1:0] shd_val
);
    always_ff @(posedge clk) begin
        if (!rst_n)    act_val <= '0;
        else if (take) act_val <= cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  shd_val <= '0;
        else if (bnd && !shdw_bypass) shd_val <= act_val;
    end
endmodule

// File: rtl/cwu_read_port.sv
module cwu_read_port #(
    parameter int          DW       = 16,
    parameter int          AW       = 4,
    parameter logic [AW-1:0] CAP_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_stb,
    input  logic [AW-1:0] addr,
    input  logic          shdw_bypass,
    input  logic [DW-1:0] act_val,
    input  logic [DW-1:0] shd_val,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] sel_val;

    assign sel_val = shdw_bypass ? act_val : shd_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) rd_data <= (addr == CAP_ADDR) ? sel_val : '0;
        end
    end
endmodule

// File: rtl/capture_window_unit.sv
module capture_window_unit #(
    parameter int            DW       = 16,
    parameter int            AW       = 4,
    parameter logic [AW-1:0] CAP_ADDR = 4'h6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] tb_count,
    input  logic          prd_hit,
    input  logic          zero_hit,
    input  logic          evt_in,
    input  logic          cap_en,
    input  logic          shdw_bypass,
    input  logic          bnd_sel,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic          rise, take, locked, bnd_hit;
    logic [DW-1:0] act_val, shd_val;
    logic          unused_wr;

    assign bnd_hit   = bnd_sel ? prd_hit : zero_hit;
    assign unused_wr = wr_stb ^ (^wr_data);

    cwu_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(evt_in), .rise(rise)
    );

    cwu_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .rise(rise),
        .bnd(bnd_hit), .take(take), .locked(locked)
    );

    cwu_cap_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .take(take), .bnd(bnd_hit),
        .shdw_bypass(shdw_bypass), .cnt(tb_count),
        .act_val(act_val), .shd_val(shd_val)
    );

    cwu_read_port #(.DW(DW), .AW(AW), .CAP_ADDR(CAP_ADDR)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .addr(addr),
        .shdw_bypass(shdw_bypass), .act_val(act_val), .shd_val(shd_val),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/cwu_chk.sv
module cwu_chk #(
    parameter int            DW       = 16,
    parameter int            AW       = 4,
    parameter logic [AW-1:0] CAP_ADDR = 4'h6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cap_en,
    input logic          shdw_bypass,
    input logic          rd_stb,
    input logic [AW-1:0] addr,
    input logic          locked,
    input logic          bnd_hit,
    input logic [DW-1:0] act_val,
    input logic [DW-1:0] shd_val,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid
);
    // R2
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(act_val));
    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !bnd_hit) |=> $stable(act_val));
    // R6
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> !locked);
    // R7
    shadow_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_hit && !shdw_bypass) |=> (shd_val == $past(act_val)));
    // R8
    bypass_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && addr == CAP_ADDR && shdw_bypass) |=> (rd_data == $past(act_val)));
    // R9
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
    // R10
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);
endmodule

bind capture_window_unit cwu_chk #(.DW(DW), .AW(AW), .CAP_ADDR(CAP_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .shdw_bypass(shdw_bypass),
    .rd_stb(rd_stb), .addr(addr), .locked(locked), .bnd_hit(bnd_hit),
    .act_val(act_val), .shd_val(shd_val), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/capture_window_unit_test.sv
`timescale 1ns/1ps
module capture_window_unit_test;
    localparam logic [3:0]  CADDR = 4'h6;
    localparam logic [15:0] PRD_V = 16'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_count = '0;
    logic        prd_hit, zero_hit;
    logic        evt_in = 0, cap_en = 0, shdw_bypass = 0, bnd_sel = 0;
    logic        rd_stb = 0, wr_stb = 0;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic        m_evtq = 0, m_lock = 0;
    logic [15:0] m_act = '0, m_shd = '0;

    always #2.5 clk = ~clk;
    assign prd_hit  = (tb_count == PRD_V);
    assign zero_hit = (tb_count == 16'd0);

    capture_window_unit uut (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .prd_hit(prd_hit),
        .zero_hit(zero_hit), .evt_in(evt_in), .cap_en(cap_en),
        .shdw_bypass(shdw_bypass), .bnd_sel(bnd_sel), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic f_bnd(logic sel, logic [15:0] c);
        return sel ? (c == PRD_V) : (c == 16'd0);
    endfunction

    function automatic logic [15:0] f_read(logic byp, logic [3:0] a,
                                           logic [15:0] act, logic [15:0] shd);
        if (a != CADDR) return 16'd0;
        return byp ? act : shd;
    endfunction

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic [15:0] c, logic en, logic byp, logic sel,
                        logic ev, logic rd, logic wr, logic [3:0] a);
        logic [15:0] exp_rd;
        logic        b, cap;
        tb_count = c; cap_en = en; shdw_bypass = byp; bnd_sel = sel;
        evt_in = ev; rd_stb = rd; wr_stb = wr; addr = a;
        wr_data = 16'($urandom);
        exp_rd = f_read(byp, a, m_act, m_shd);
        @(posedge clk);
        b   = f_bnd(sel, c);
        cap = en && ev && !m_evtq && (!m_lock || b);
        if (b && !byp) m_shd = m_act;
        if (cap) m_act = c;
        m_lock = !en ? 1'b0 : (cap ? 1'b1 : (b ? 1'b0 : m_lock));
        m_evtq = ev;
        #1;
        check_eq({tag, " R9 valid"}, 32'(rd_valid), 32'(rd));
        if (rd) check_eq({tag, " R9 data"}, 32'(rd_data), 32'(exp_rd));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check_eq("R1 reset data", 32'(rd_data), 0);
        check_eq("R1 reset valid", 32'(rd_valid), 0);
        rst_n = 1'b1;
        step("R1", 16'd1, 0, 1, 1, 0, 1, 0, CADDR);
        check_eq("R1 read zero", 32'(rd_data), 0);
        // R3 capture and held level
        step("R3", 16'd1, 1, 1, 1, 0, 0, 0, CADDR);
        step("R3", 16'd5, 1, 1, 1, 1, 0, 0, CADDR);
        step("R3", 16'd6, 1, 1, 1, 1, 1, 0, CADDR);
        check_eq("R3 capture", 32'(rd_data), 5);
        // R4 lockout, wrong boundary ignored
        step("R4", 16'd7, 1, 1, 1, 0, 0, 0, CADDR);
        step("R4", 16'd8, 1, 1, 1, 1, 0, 0, CADDR);
        step("R4", 16'd9, 1, 1, 1, 0, 1, 0, CADDR);
        check_eq("R4 locked", 32'(rd_data), 5);
        step("R4", 16'd0, 1, 1, 1, 1, 0, 0, CADDR);
        step("R4", 16'd1, 1, 1, 1, 0, 1, 0, CADDR);
        check_eq("R4 zero not selected", 32'(rd_data), 5);
        // R5 edge on boundary
        step("R5", PRD_V, 1, 1, 1, 1, 0, 0, CADDR);
        step("R5", 16'd2, 1, 1, 1, 0, 1, 0, CADDR);
        check_eq("R5 taken on boundary", 32'(rd_data), 20);
        step("R5", 16'd3, 1, 1, 1, 1, 0, 0, CADDR);
        step("R5", 16'd4, 1, 1, 1, 0, 1, 0, CADDR);
        check_eq("R5 relocked", 32'(rd_data), 20);
        // R6 disable clears lock
        step("R6", 16'd5, 0, 1, 1, 0, 0, 0, CADDR);
        step("R6", 16'd6, 1, 1, 1, 1, 0, 0, CADDR);
        step("R6", 16'd7, 1, 1, 1, 0, 1, 0, CADDR);
        check_eq("R6 first edge", 32'(rd_data), 6);
        // R2 disabled
        step("R2", 16'd9, 0, 1, 1, 1, 0, 0, CADDR);
        step("R2", 16'd10, 0, 1, 1, 0, 1, 0, CADDR);
        check_eq("R2 no capture", 32'(rd_data), 6);
        // R7 shadow
        step("R7", 16'd11, 1, 0, 0, 0, 1, 0, CADDR);
        check_eq("R7 shadow stale", 32'(rd_data), 0);
        step("R7", 16'd0, 1, 0, 0, 0, 0, 0, CADDR);
        step("R7", 16'd1, 1, 0, 0, 0, 1, 0, CADDR);
        check_eq("R7 shadow refreshed", 32'(rd_data), 6);
        step("R7", 16'd2, 1, 0, 0, 1, 0, 0, CADDR);
        step("R7", 16'd3, 1, 0, 0, 0, 1, 0, CADDR);
        check_eq("R7 shadow holds", 32'(rd_data), 6);
        // R8 bypass
        step("R8", 16'd4, 1, 1, 0, 0, 1, 0, CADDR);
        check_eq("R8 active", 32'(rd_data), 2);
        // R9 other address
        step("R9", 16'd5, 1, 1, 0, 0, 1, 0, 4'h3);
        check_eq("R9 other addr", 32'(rd_data), 0);
        // R10 writes ignored
        step("R10", 16'd6, 1, 1, 0, 0, 0, 1, CADDR);
        check_eq("R10 no valid on write", 32'(rd_valid), 0);
        step("R10", 16'd7, 1, 1, 0, 0, 1, 0, CADDR);
        check_eq("R10 value kept", 32'(rd_data), 2);
        // random phase
        begin
            logic [15:0] c = 16'd8;
            logic en = 1, byp = 0, sel = 0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 63) == 0) en  = ~en;
                if ($urandom_range(0, 99) == 0) byp = ~byp;
                if ($urandom_range(0, 99) == 0) sel = ~sel;
                step("R3R4R7 random", c, en, byp, sel, 1'($urandom_range(0, 2) == 0),
                     1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 7) == 0),
                     ($urandom_range(0, 5) == 0) ? 4'($urandom) : CADDR);
                c = (c == PRD_V) ? 16'd0 : c + 16'd1;
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule